// File: doc/BRIEF.md
# SIMT Lane Execution Mask Unit

This block holds the execution mask of one wavefront in a SIMT processor. Each bit of the mask enables one vector lane, and a lane whose bit is clear does no work. The block carries out divergent if/else/end and loop-break control only by save-and-modify operations on that mask. It has no predicate stack. The saved masks live in the scalar register file, which is outside this block. The program passes a saved mask back in with each command and stores the mask the block returns.

Each command is taken on a valid/ready handshake and finishes in one cycle. A command carries an opcode, a per-lane condition from a vector compare, and a saved-mask operand. One registered cycle later the block presents the new execution mask, the returned mask, a zero flag that lets the program skip a body, and a nonzero flag that lets it branch back to the head of a loop. A narrow mode runs the same arithmetic on the low 32 lanes and holds the upper lanes at zero.

Top module: `lane_mask_ctrl`

## Requirements
- R1: While `rst` is high, `cmd_ready` is 0. After reset the outputs are: `exec_mask` all ones (the low 32 lanes only when `narrow` is high during reset), `ret_mask` 0, `rsp_valid` 0, `exec_zero` 0 and `exec_nonzero` 1. `cmd_ready` is 1 from the first cycle after reset.
- R2: Opcode 3'd0 (if) with `cmd_simple`=0 sets the new mask to E & C and returns E ^ (E & C). Here E is the current mask, C the condition and S the saved operand, each ANDed with the enabled lanes.
- R3: Opcode 3'd0 with `cmd_simple`=1 sets the same new mask as R2 and returns the whole of E.
- R4: Opcode 3'd1 (else) forms M = E | S, returns T = M & E, and sets the new mask to M ^ T.
- R5: Opcode 3'd2 (end) sets the new mask to E | S and returns 0.
- R6: Opcode 3'd3 (if-break) leaves the mask at E and returns (C & E) | S. With `cmd_premasked`=1 it returns C | S.
- R7: Opcode 3'd4 (loop) sets the new mask to E & ~S and returns 0. Its nonzero flag is the loop-back decision.
- R8: Opcode 3'd5 (direct write) sets the new mask to C and returns E.
- R9: After every accepted command, `exec_zero` is 1 exactly when the new mask is 0, and `exec_nonzero` is its complement. Both flags are computed on the updated mask, never on the mask before the update.
- R10: When `narrow`=1, lanes 63:32 of E, C and S are treated as 0. The written mask and the returned mask therefore have those bits clear, and the zero test ignores them.
- R11: Results appear on the cycle after acceptance, with `rsp_valid` high for exactly that one cycle. Without acceptance the mask does not change. Opcodes 3'd6 and 3'd7 leave the mask at E and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow | input | 1 | 32-lane mode select |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Command opcode |
| cmd_cond | input | LANES | Per-lane condition, or the new mask for a direct write |
| cmd_saved | input | LANES | Saved-mask operand |
| cmd_simple | input | 1 | If without else: return the whole old mask |
| cmd_premasked | input | 1 | If-break condition is already masked |
| rsp_valid | output | 1 | Results below were updated last cycle |
| exec_mask | output | LANES | Execution mask |
| ret_mask | output | LANES | Mask the program must save |
| exec_zero | output | 1 | Execution mask is all zero |
| exec_nonzero | output | 1 | Execution mask has an active lane |

## Verification
Every opcode and both variant bits are swept over a cross of starting masks, conditions and saved masks. The pattern set holds all-zero, all-ones, alternating lanes, low-half-only, high-half-plus-lane-0 and top-lane-only masks. The alternating and half patterns separate AND, OR and XOR mistakes. The zero and all-ones patterns drive the zero and nonzero flags to both values. Running the high-half patterns in narrow mode shows whether the upper lanes leak into the masks or into the zero test. An idle cycle confirms that the mask is held.

// File: rtl/lmask_pkg.sv
package lmask_pkg;
  typedef enum logic [2:0] {
    OP_IF   = 3'd0,
    OP_ELSE = 3'd1,
    OP_END  = 3'd2,
    OP_BRK  = 3'd3,
    OP_LOOP = 3'd4,
    OP_SET  = 3'd5
  } lmask_op_e;
endpackage

// File: rtl/lmask_lane_gate.sv
module lmask_lane_gate #(
  parameter int LANES        = 64,
  parameter int NARROW_LANES = 32
) (
  input  logic             narrow,
  output logic [LANES-1:0] lane_en
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < NARROW_LANES) begin : g_low
      assign lane_en[i] = 1'b1;
    end else begin : g_high
      assign lane_en[i] = ~narrow;
    end
  end
endmodule

// File: rtl/lmask_alu.sv
module lmask_alu
  import lmask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [2:0]       op,
  input  logic [LANES-1:0] cur,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] saved,
  input  logic [LANES-1:0] lane_en,
  input  logic             simple,
  input  logic             premasked,
  output logic [LANES-1:0] nxt,
  output logic [LANES-1:0] ret
);
  logic [LANES-1:0] e, c, s, taken, merged, then_l;

  assign e      = cur & lane_en;
  assign c      = cond & lane_en;
  assign s      = saved & lane_en;
  assign taken  = e & c;
  assign merged = e | s;
  assign then_l = merged & e;

  always_comb begin
    nxt = e;
    ret = '0;
    case (lmask_op_e'(op))
      OP_IF: begin
        nxt = taken;
        ret = simple ? e : (e ^ taken);
      end
      OP_ELSE: begin
        nxt = merged ^ then_l;
        ret = then_l;
      end
      OP_END:  nxt = merged;
      OP_BRK:  ret = (premasked ? c : taken) | s;
      OP_LOOP: nxt = e & ~s;
      OP_SET: begin
        nxt = c;
        ret = e;
      end
      default: begin
        nxt = e;
        ret = '0;
      end
    endcase
  end
endmodule

// File: rtl/lmask_flags.sv
module lmask_flags #(
  parameter int LANES = 64,
  parameter int GROUP = 16
) (
  input  logic [LANES-1:0] mask,
  output logic             zero,
  output logic             nonzero
);
  localparam int NGRP = (LANES + GROUP - 1) / GROUP;
  logic [NGRP-1:0] grp_any;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GROUP;
    localparam int HI = ((LO + GROUP) > LANES) ? LANES - 1 : LO + GROUP - 1;
    assign grp_any[g] = |mask[HI:LO];
  end

  assign nonzero = |grp_any;
  assign zero    = ~nonzero;
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl #(
  parameter int LANES        = 64,
  parameter int NARROW_LANES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             narrow,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [LANES-1:0] cmd_cond,
  input  logic [LANES-1:0] cmd_saved,
  input  logic             cmd_simple,
  input  logic             cmd_premasked,
  output logic             rsp_valid,
  output logic [LANES-1:0] exec_mask,
  output logic [LANES-1:0] ret_mask,
  output logic             exec_zero,
  output logic             exec_nonzero
);
  logic [LANES-1:0] lane_en, nxt, ret;
  logic             nz_d, z_d, accept;
  logic [LANES-1:0] exec_q, ret_q;
  logic             zero_q, nz_q, rsp_q, rdy_q;

  assign accept = cmd_valid & rdy_q;

  lmask_lane_gate #(.LANES(LANES), .NARROW_LANES(NARROW_LANES)) u_gate (
    .narrow  (narrow),
    .lane_en (lane_en)
  );

  lmask_alu #(.LANES(LANES)) u_alu (
    .op        (cmd_op),
    .cur       (exec_q),
    .cond      (cmd_cond),
    .saved     (cmd_saved),
    .lane_en   (lane_en),
    .simple    (cmd_simple),
    .premasked (cmd_premasked),
    .nxt       (nxt),
    .ret       (ret)
  );

  lmask_flags #(.LANES(LANES)) u_flags (
    .mask    (nxt),
    .zero    (z_d),
    .nonzero (nz_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q <= lane_en;
      ret_q  <= '0;
      zero_q <= 1'b0;
      nz_q   <= 1'b1;
      rsp_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      rsp_q <= accept;
      if (accept) begin
        exec_q <= nxt;
        ret_q  <= ret;
        zero_q <= z_d;
        nz_q   <= nz_d;
      end
    end
  end

  assign cmd_ready    = rdy_q;
  assign rsp_valid    = rsp_q;
  assign exec_mask    = exec_q;
  assign ret_mask     = ret_q;
  assign exec_zero    = zero_q;
  assign exec_nonzero = nz_q;
endmodule

// File: rtl/lmask_chk.sv
module lmask_chk #(
  parameter int LANES        = 64,
  parameter int NARROW_LANES = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             narrow,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [LANES-1:0] cmd_saved,
  input logic             rsp_valid,
  input logic [LANES-1:0] exec_mask,
  input logic             exec_zero,
  input logic             exec_nonzero
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R11
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);

  // R11
  idle_holds_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (!rsp_valid && $stable(exec_mask)));

  // R9
  zero_flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((exec_zero == (exec_mask == '0)) && (exec_nonzero != exec_zero)));

  // R6
  break_keeps_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd3 && !narrow) |=> $stable(exec_mask));

  // R7
  loop_clears_broken_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd4) |=> ((exec_mask & $past(cmd_saved)) == '0));

  // R5
  end_loses_no_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd2 && !narrow) |=> (($past(exec_mask) & ~exec_mask) == '0));

  // R10
  narrow_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && narrow) |=> ((exec_mask >> NARROW_LANES) == '0));
endmodule

bind lane_mask_ctrl lmask_chk #(.LANES(LANES), .NARROW_LANES(NARROW_LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .narrow       (narrow),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .cmd_saved    (cmd_saved),
  .rsp_valid    (rsp_valid),
  .exec_mask    (exec_mask),
  .exec_zero    (exec_zero),
  .exec_nonzero (exec_nonzero)
);

// File: tb/test_lane_mask_ctrl.sv
module test_lane_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        narrow;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [63:0] cmd_cond, cmd_saved;
  logic        cmd_simple, cmd_premasked;
  logic        rsp_valid;
  logic [63:0] exec_mask, ret_mask;
  logic        exec_zero, exec_nonzero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] m_exec;

  always #2.5 clk = ~clk;

  lane_mask_ctrl i_lane_mask_ctrl (
    .clk(clk), .rst(rst), .narrow(narrow), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_cond(cmd_cond),
    .cmd_saved(cmd_saved), .cmd_simple(cmd_simple),
    .cmd_premasked(cmd_premasked), .rsp_valid(rsp_valid),
    .exec_mask(exec_mask), .ret_mask(ret_mask), .exec_zero(exec_zero),
    .exec_nonzero(exec_nonzero)
  );

  function automatic logic [63:0] pat(input int k);
    case (k)
      0: pat = 64'h0;
      1: pat = '1;
      2: pat = 64'h5555_5555_5555_5555;
      3: pat = 64'h0000_0000_FFFF_FFFF;
      4: pat = 64'hFFFF_FFFF_0000_0001;
      default: pat = 64'h8000_0000_0000_0000;
    endcase
  endfunction

  function automatic string tag_of(input int op, input bit t);
    case (op)
      0: tag_of = t ? "R3" : "R2";
      1: tag_of = "R4";
      2: tag_of = "R5";
      3: tag_of = "R6";
      4: tag_of = "R7";
      5: tag_of = "R8";
      default: tag_of = "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Expected results taken from the requirement formulas
  task automatic expect_of(input int op, input logic [63:0] e0, c0, s0,
                           input bit t, input bit nar,
                           output logic [63:0] ne, output logic [63:0] r);
    logic [63:0] en, e, c, s, m;
    en = nar ? 64'h0000_0000_FFFF_FFFF : '1;
    e = e0 & en; c = c0 & en; s = s0 & en;
    ne = e; r = '0;
    case (op)
      0: begin ne = e & c; r = t ? e : (e ^ (e & c)); end
      1: begin m = e | s; r = m & e; ne = m ^ r; end
      2: ne = e | s;
      3: r = (t ? c : (c & e)) | s;
      4: ne = e & ~s;
      5: begin ne = c; r = e; end
      default: begin ne = e; r = '0; end
    endcase
  endtask

  // Called at a falling edge; returns at the next falling edge with results visible
  task automatic run(input int op, input logic [63:0] c, s,
                     input bit t, input bit nar, input string tag);
    logic [63:0] ne, r;
    expect_of(op, m_exec, c, s, t, nar, ne, r);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_cond = c; cmd_saved = s;
    cmd_simple = t; cmd_premasked = t; narrow = nar;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tag, "exec_mask", exec_mask, ne);
    chk(tag, "ret_mask", ret_mask, r);
    chk("R11", "rsp_valid", {63'b0, rsp_valid}, 64'd1);
    chk("R9", "exec_zero", {63'b0, exec_zero}, {63'b0, ne == 64'h0});
    chk("R9", "exec_nonzero", {63'b0, exec_nonzero}, {63'b0, ne != 64'h0});
    if (nar) chk("R10", "upper lanes", exec_mask >> 32, 64'h0);
    m_exec = ne;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; narrow = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
    cmd_cond = '0; cmd_saved = '0; cmd_simple = 1'b0; cmd_premasked = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cmd_ready in reset", {63'b0, cmd_ready}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "exec_mask", exec_mask, '1);
    chk("R1", "ret_mask", ret_mask, 64'h0);
    chk("R1", "rsp_valid", {63'b0, rsp_valid}, 64'd0);
    chk("R1", "exec_zero", {63'b0, exec_zero}, 64'd0);
    chk("R1", "exec_nonzero", {63'b0, exec_nonzero}, 64'd1);
    chk("R1", "cmd_ready", {63'b0, cmd_ready}, 64'd1);
    m_exec = '1;

    for (int nar = 0; nar < 2; nar++)
      for (int op = 0; op < 8; op++)
        for (int t = 0; t < 2; t++)
          for (int ei = 0; ei < 6; ei++)
            for (int ci = 0; ci < 6; ci++)
              for (int si = 0; si < 6; si++) begin
                run(5, pat(ei), pat(si), 1'b0, nar[0], "R8");
                run(op, pat(ci), pat(si), t[0], nar[0], tag_of(op, t[0]));
              end

    // R11: an idle cycle leaves the mask and raises no response
    run(5, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0, 1'b0, "R8");
    @(negedge clk);
    chk("R11", "idle rsp_valid", {63'b0, rsp_valid}, 64'd0);
    chk("R11", "idle exec_mask", exec_mask, 64'h1234_5678_9ABC_DEF0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule